// File: doc/BRIEF.md
# Multi-Player Joypad Multiplexer

This block keeps a cached button byte for each of up to four controllers and serves those bytes to a handheld CPU. The handheld sees only two active-low select lines and a 4-bit return nibble. A host processor writes the cached bytes into four controller registers. It also writes a control register that sets how many players are active: one, two or four.

The handheld reads the cache through its select lines. Pulling the direction line low returns the direction half of the active controller's byte. Pulling the button line low returns the button half. Raising both lines together moves to the next controller and returns an ID nibble, which lets software find the active player and detect that more than one player is present. The result is registered, so the nibble appears one clock after the select lines that produce it.

Top module: `joypad_player_mux`

## Requirements
- R1: After a synchronous reset, every controller byte is 0xFF (all released), the player index is 0, one-player mode is active and the output nibble is 0xF.
- R2: A host write to address 0, 1, 2 or 3 stores the data byte for player 1, 2, 3 or 4. Writes to addresses 5, 6 and 7 change nothing.
- R3: Each controller byte is stored and returned exactly as written, with 1 meaning released and 0 meaning pressed. Bits 3..0 are Down, Up, Left and Right. Bits 7..4 are Start, Select, B and A.
- R4: With only the direction select (`sel_dir_n`) low, the output is bits 3..0 of the active player's byte.
- R5: With only the button select (`sel_btn_n`) low, the output is bits 7..4 of the active player's byte.
- R6: With both selects low, the output is the bitwise AND of the two halves of the active player's byte.
- R7: With both selects high, the output is 0xF minus the player index.
- R8: The index advances only on a cycle where both selects are high and were not both high on the previous cycle. Holding both high does not advance it again.
- R9: The index wraps modulo the active player count, so it stays at 0 in one-player mode.
- R10: A write to address 4 sets the mode from the data byte. Bit 5 set selects four players, whatever bit 4 holds. Otherwise bit 4 set selects two players. Both clear selects one player.
- R11: A write to address 4 that changes the mode sets the index to 0. This takes priority over an advance in the same cycle. A write that keeps the same mode leaves the index as it is.
- R12: The output nibble is registered. It reflects the select lines and the index as updated on the same clock edge, and the controller bytes as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address (0-3 controllers, 4 control) |
| host_wdata | input | 8 | Host write data |
| sel_dir_n | input | 1 | Direction-half select, active low |
| sel_btn_n | input | 1 | Button-half select, active low |
| pad_nibble | output | 4 | Registered nibble returned to the handheld |

## Verification
The controllers are loaded with distinct asymmetric bytes. This exposes a swapped nibble, a wrong player slot or an OR in place of the AND. Single strobe pulses are run in each mode to show the wrap point, and a long hold of both lines shows whether the design advances on a level instead of an edge. Control writes repeat the same mode, set both mode bits, and land on the same cycle as a strobe edge. These cases separate a mode-change reset from any write resetting the index, and check that the reset takes priority over an advance.

// File: rtl/jpm_pkg.sv
package jpm_pkg;
  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_TWO  = 2'd1,
    MODE_FOUR = 2'd2
  } mode_e;

  localparam logic [3:0] ID_BASE = 4'hF;
endpackage

// File: rtl/pad_bank.sv
module pad_bank #(
  parameter int NUM_PADS = 4,
  parameter int PAD_W    = 8,
  parameter int ADDR_W   = 3,
  localparam int IDX_W   = $clog2(NUM_PADS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PAD_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PAD_W-1:0]  rd_data
);
  logic [PAD_W-1:0] pad_q [NUM_PADS];

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst)
        pad_q[g] <= '1;
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        pad_q[g] <= wr_data;
    end
  end

  assign rd_data = pad_q[rd_idx];

  // R1: the byte seen by the reader is all-released right after reset
  assert_reset_released_R1: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '1));

  // R2: an in-range write lands in the addressed slot
  assert_write_stored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr < ADDR_W'(NUM_PADS))) |=>
      (pad_q[IDX_W'($past(wr_addr))] == $past(wr_data)));
endmodule

// File: rtl/player_seq.sv
module player_seq
  import jpm_pkg::*;
#(
  parameter int NUM_PADS = 4,
  localparam int IDX_W   = $clog2(NUM_PADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_data,
  input  logic             sel_dir_n,
  input  logic             sel_btn_n,
  output logic [IDX_W-1:0] idx_d,
  output logic [IDX_W-1:0] idx_q
);
  mode_e          mode_q, mode_new;
  logic           both_hi, prev_both_q, rise, mode_chg;
  logic [IDX_W:0] cnt_q;

  assign both_hi = sel_dir_n && sel_btn_n;
  assign rise    = both_hi && !prev_both_q;

  always_comb begin
    if (ctrl_data[5])      mode_new = MODE_FOUR;
    else if (ctrl_data[4]) mode_new = MODE_TWO;
    else                   mode_new = MODE_ONE;
  end

  assign mode_chg = ctrl_we && (mode_new != mode_q);

  always_comb begin
    unique case (mode_q)
      MODE_FOUR: cnt_q = (IDX_W+1)'(NUM_PADS);
      MODE_TWO:  cnt_q = (IDX_W+1)'(2);
      default:   cnt_q = (IDX_W+1)'(1);
    endcase
  end

  always_comb begin
    idx_d = idx_q;
    if (mode_chg)
      idx_d = '0;
    else if (rise)
      idx_d = ({1'b0, idx_q} == cnt_q - 1'b1) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_ONE;
      idx_q       <= '0;
      prev_both_q <= 1'b1;
    end else begin
      if (ctrl_we) mode_q <= mode_new;
      idx_q       <= idx_d;
      prev_both_q <= both_hi;
    end
  end

  // R9: index never reaches the player count
  assert_idx_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, idx_q} < cnt_q));

  // R9: single-player mode pins the index at zero
  assert_single_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ONE) |-> (idx_q == '0));

  // R8: no advance without a fresh both-high edge
  assert_hold_without_edge_R8: assert property (@(posedge clk) disable iff (rst)
    (!rise && !ctrl_we) |=> $stable(idx_q));

  // R11: a mode change clears the index
  assert_mode_clears_idx_R11: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (idx_q == '0));
endmodule

// File: rtl/nibble_out.sv
module nibble_out
  import jpm_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int PAD_W    = 8,
  localparam int IDX_W   = $clog2(NUM_PADS),
  localparam int HALF_W  = PAD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_dir_n,
  input  logic              sel_btn_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PAD_W-1:0]  pad_byte,
  output logic [HALF_W-1:0] nib_q
);
  logic [HALF_W-1:0] nib_d, dir_half, btn_half;

  assign dir_half = pad_byte[HALF_W-1:0];
  assign btn_half = pad_byte[PAD_W-1:HALF_W];

  always_comb begin
    unique case ({sel_btn_n, sel_dir_n})
      2'b11:   nib_d = HALF_W'(ID_BASE) - HALF_W'(idx);
      2'b10:   nib_d = dir_half;
      2'b01:   nib_d = btn_half;
      default: nib_d = dir_half & btn_half;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) nib_q <= HALF_W'(ID_BASE);
    else     nib_q <= nib_d;
  end

  // R7: both selects high yields the ID nibble one clock later
  assert_id_nibble_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_dir_n && sel_btn_n) |=> (nib_q == HALF_W'(ID_BASE) - HALF_W'($past(idx))));

  // R6: both low never returns a bit set that either half has clear
  assert_and_merge_R6: assert property (@(posedge clk) disable iff (rst)
    (!sel_dir_n && !sel_btn_n) |=>
      ((nib_q & ~$past(dir_half)) == '0) && ((nib_q & ~$past(btn_half)) == '0));
endmodule

// File: rtl/joypad_player_mux.sv
module joypad_player_mux
  import jpm_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int PAD_W    = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [PAD_W-1:0]  host_wdata,
  input  logic              sel_dir_n,
  input  logic              sel_btn_n,
  output logic [3:0]        pad_nibble
);
  localparam int IDX_W = $clog2(NUM_PADS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PADS);

  logic             pad_we, ctrl_we;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic [PAD_W-1:0] pad_byte;

  assign pad_we  = host_we && (host_addr < CTRL_ADDR);
  assign ctrl_we = host_we && (host_addr == CTRL_ADDR);

  pad_bank #(.NUM_PADS(NUM_PADS), .PAD_W(PAD_W), .ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rst(rst), .wr_en(pad_we), .wr_addr(host_addr),
    .wr_data(host_wdata), .rd_idx(idx_d), .rd_data(pad_byte)
  );

  player_seq #(.NUM_PADS(NUM_PADS)) seq_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_data(host_wdata[7:0]),
    .sel_dir_n(sel_dir_n), .sel_btn_n(sel_btn_n), .idx_d(idx_d), .idx_q(idx_q)
  );

  nibble_out #(.NUM_PADS(NUM_PADS), .PAD_W(PAD_W)) out_i (
    .clk(clk), .rst(rst), .sel_dir_n(sel_dir_n), .sel_btn_n(sel_btn_n),
    .idx(idx_d), .pad_byte(pad_byte), .nib_q(pad_nibble)
  );

  // R12: the output only moves on a clock edge and holds while inputs and state hold
  assert_registered_out_R12: assert property (@(posedge clk) disable iff (rst)
    ($stable(idx_q) && $stable({sel_dir_n, sel_btn_n}) && !$past(host_we) && !host_we)
      |=> $stable(pad_nibble));
endmodule

// File: tb/joypad_player_mux_tb.sv
module joypad_player_mux_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       sel_dir_n = 1'b1;
  logic       sel_btn_n = 1'b1;
  logic [3:0] pad_nibble;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // behavioural reference state
  int m_pads [4];
  int m_cnt, m_idx, m_out;
  bit m_prev;

  always #2 clk = ~clk;

  joypad_player_mux dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .sel_dir_n(sel_dir_n), .sel_btn_n(sel_btn_n),
    .pad_nibble(pad_nibble)
  );

  task automatic model_edge(input bit d, input bit b, input bit we, input int a, input int dat);
    if (rst) begin
      foreach (m_pads[i]) m_pads[i] = 255;
      m_cnt = 1; m_idx = 0; m_out = 15; m_prev = 1'b1;
    end else begin
      bit both, rise, chg;
      int ncnt, nidx, pv;
      both = d && b;
      rise = both && !m_prev;
      ncnt = (dat & 32) ? 4 : ((dat & 16) ? 2 : 1);
      chg  = we && (a == 4) && (ncnt != m_cnt);
      nidx = chg ? 0 : (rise ? (m_idx + 1) % m_cnt : m_idx);
      pv   = m_pads[nidx];
      if (both)         m_out = 15 - nidx;
      else if (!d && !b) m_out = (pv & 15) & (pv >> 4);
      else if (!d)      m_out = pv & 15;
      else              m_out = pv >> 4;
      if (we && a < 4)  m_pads[a] = dat;
      if (we && a == 4) m_cnt = ncnt;
      m_idx  = nidx;
      m_prev = both;
    end
  endtask

  task automatic step(input bit d, input bit b, input bit we, input int a, input int dat,
                      input string req);
    @(negedge clk);
    sel_dir_n = d; sel_btn_n = b; host_we = we;
    host_addr = 3'(a); host_wdata = 8'(dat);
    @(posedge clk);
    model_edge(d, b, we, a, dat);
    #1;
    n_checks++;
    if (pad_nibble !== 4'(m_out)) begin
      n_fail++;
      $display("FAIL %s: pad_nibble actual=%h expected=%h", req, pad_nibble, 4'(m_out));
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0, req);
  endtask

  task automatic wr(input int a, input int dat, input string req);
    step(1, 1, 1, a, dat, req);
  endtask

  task automatic strobe(input string req);
    step(0, 1, 0, 0, 0, req);
    step(1, 1, 0, 0, 0, req);
  endtask

  task automatic read_all(input string req);
    step(0, 1, 0, 0, 0, {req, " R4"});
    step(1, 0, 0, 0, 0, {req, " R5"});
    step(0, 0, 0, 0, 0, {req, " R6"});
    step(1, 1, 0, 0, 0, {req, " R7"});
  endtask

  initial begin
    // R1: reset state
    step(1, 1, 0, 0, 0, "R1");
    step(1, 1, 0, 0, 0, "R1");
    rst = 1'b0;
    idle(2, "R1");
    read_all("R1");

    // R2/R3: distinct bytes; out-of-range addresses ignored
    wr(0, 8'hA5, "R2");
    wr(1, 8'h3C, "R2");
    wr(2, 8'h96, "R2");
    wr(3, 8'h7E, "R3");
    wr(5, 8'h00, "R2");
    wr(6, 8'h00, "R2");
    wr(7, 8'h00, "R2");
    read_all("R3");

    // R9: one player, strobes keep index 0
    for (int i = 0; i < 3; i++) strobe("R9");
    read_all("R9");

    // R10: two players, walk and wrap
    wr(4, 8'h10, "R10");
    for (int i = 0; i < 3; i++) begin
      strobe("R8");
      read_all("R9");
    end
    // R8: long hold of both-high does not advance
    idle(6, "R8");
    read_all("R8");

    // R10: both mode bits set -> four players
    wr(4, 8'h30, "R10");
    for (int i = 0; i < 5; i++) begin
      strobe("R9");
      read_all("R9");
    end
    // R11: same mode rewritten keeps index
    wr(4, 8'h20, "R11");
    read_all("R11");
    // R11: mode change with coincident advance edge
    step(0, 1, 0, 0, 0, "R11");
    step(1, 1, 1, 4, 8'h10, "R11");
    read_all("R11");
    strobe("R11");
    wr(4, 8'h01, "R11");
    read_all("R11");

    // R12: write during read is seen one edge later
    wr(4, 8'h20, "R12");
    step(0, 1, 1, 0, 8'h5A, "R12");
    step(0, 1, 0, 0, 0, "R12");
    step(1, 0, 1, 0, 8'hC3, "R12");
    step(1, 0, 0, 0, 0, "R12");

    // R1: reset again mid-run
    rst = 1'b1;
    step(0, 1, 0, 0, 0, "R1");
    rst = 1'b0;
    read_all("R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule